// File: doc/BRIEF.md
# Line-Rate Reconfiguration Sequencer

This block retunes a serial link to one of four line rates (2.0, 2.5, 3.125 or 5.0 Gb/s) when it gets a start pulse. It steps through a fixed list of register entries. Each entry goes out as a DRP access on a single master port, and a target-select bit routes that access either to the transceiver channel or to the clock manager. The divider and filter words are constants held in a table; the block does not compute them.

Channel entries are plain writes. Each clock-manager entry is done as a read, then a write that merges the value read back with the new value. Reserved bits therefore keep whatever the register held before. The clock manager is held in reset for the whole clock-manager phase. After the last write the block releases that reset, waits for the lock input, and then reports completion.

Top module: `lrr_seq_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `drp_en_o` and `cm_rst_o` are all 0.
- R2: A valid start issues exactly 23 DRP accesses, in this order:
  - three channel writes (`drp_tgt_o`=0) to 0x05E, 0x088 and 0x0A9;
  - then, for each clock-manager register (`drp_tgt_o`=1) in the order 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x4E, 0x4F, one read followed by one write to the same address.
- R3: The rate codes on `rate_sel_i` are 0=2.0, 1=2.5, 2=3.125 and 3=5.0 Gb/s. The channel words are:
  - 0x05E = 0x1002 for code 0 and 0x1082 for all other codes;
  - 0x088 = 0x0000 for code 3 and 0x0011 otherwise;
  - 0x0A9 = 0x1040 for code 3 and 0x1020 otherwise.
- R4: A clock-manager write is issued only after `drp_rdy_i` has answered the read of the same register.
- R5: Each clock-manager write carries (read & keep) | (new & ~keep). The keep masks are:
  - 0x08 and 0x14: 0x1000;
  - 0x15, 0x19 and 0x1A: 0x8000;
  - 0x16: 0xC000;
  - 0x18: 0xFC00;
  - 0x4E: 0x66FF;
  - 0x4F: 0x666F;
  - 0x09: 0x0000.
- R6: Bits 9:8 of the words written to 0x09 and 0x15 are always 0.
- R7: The new clock-manager values in register order are:
  - code 0: 1187, 0080, 134D, 0000, 2083, 0177, 7C01, FFE9, 0908, 1000;
  - code 1: 1042, 0080, 10C3, 0000, 0041, 03E8, 4401, C7E9, 9808, 8900;
  - code 2: 1104, 0000, 1083, 0080, 1041, 03E8, 3801, BBE9, 9108, 1900;
  - code 3 uses the code 1 values.
- R8: `drp_en_o` is high for one cycle per access, and the next access starts only after `drp_rdy_i` has answered the previous one.
- R9: `cm_rst_o` rises before the first clock-manager access, stays high through every clock-manager access, and falls after the ready of the last write.
- R10: `done_o` rises only after `cm_locked_i` is seen high following the release of `cm_rst_o`. It stays high until the next accepted start. `busy_o` is high from the accepted start until `done_o` rises.
- R11: A start pulse while `busy_o` is high has no effect on the running sequence.
- R12: A start with a code of 4 to 7 sets `err_o` and clears `done_o`, and no DRP access follows. The next valid start clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| rate_sel_i | input | 3 | Rate code |
| drp_en_o | output | 1 | DRP access strobe |
| drp_we_o | output | 1 | DRP write enable |
| drp_tgt_o | output | 1 | Target: 0 channel, 1 clock manager |
| drp_addr_o | output | 9 | DRP address |
| drp_di_o | output | 16 | DRP write data |
| drp_do_i | input | 16 | DRP read data |
| drp_rdy_i | input | 1 | DRP ready |
| cm_rst_o | output | 1 | Clock-manager reset |
| cm_locked_i | input | 1 | Clock-manager lock |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence complete and locked |
| err_o | output | 1 | Unsupported rate code |

## Verification
The hardest condition to reach is a reserved bit surviving the read-modify-write. The new-value table already agrees with many reserved positions, so that case only shows up when the read-back differs from the table in those bits. The bench's DRP slave model is therefore preloaded with different fill patterns (all ones, all zeros, alternating) before runs at different rates, and its ready latency varies from access to access. A second start is also injected in the middle of a run to confirm that the access stream stays intact.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  localparam int DRP_AW = 9;
  localparam int DRP_DW = 16;
  localparam int N_CH   = 3;
  localparam int N_CM   = 10;
  localparam int N_ENT  = N_CH + N_CM;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int RATE_W = 3;

  typedef enum logic [1:0] {RATE_2G0, RATE_2G5, RATE_3G1, RATE_5G0} rate_e;

  typedef struct packed {
    logic              cm;
    logic [DRP_AW-1:0] addr;
    logic [DRP_DW-1:0] val;
    logic [DRP_DW-1:0] keep;
    logic [DRP_DW-1:0] zero;
  } entry_t;

  function automatic logic [DRP_DW-1:0] pick3(logic [1:0] s, logic [DRP_DW-1:0] a,
                                              logic [DRP_DW-1:0] b, logic [DRP_DW-1:0] c);
    case (s)
      2'd0:    return a;
      2'd2:    return c;
      default: return b;
    endcase
  endfunction

  function automatic entry_t lookup(rate_e r, logic [IDX_W-1:0] idx);
    entry_t e;
    logic [1:0] s;
    e = '0;
    s = (r == RATE_5G0) ? 2'd1 : 2'(r);  // 5.0 reuses 2.5 clock-manager set
    case (idx)
      4'd0:  begin e.addr = 9'h05E; e.val = (r == RATE_2G0) ? 16'h1002 : 16'h1082; end
      4'd1:  begin e.addr = 9'h088; e.val = (r == RATE_5G0) ? 16'h0000 : 16'h0011; end
      4'd2:  begin e.addr = 9'h0A9; e.val = (r == RATE_5G0) ? 16'h1040 : 16'h1020; end
      4'd3:  begin e.cm = 1'b1; e.addr = 9'h008; e.keep = 16'h1000;
                   e.val = pick3(s, 16'h1187, 16'h1042, 16'h1104); end
      4'd4:  begin e.cm = 1'b1; e.addr = 9'h009; e.zero = 16'h0300;
                   e.val = pick3(s, 16'h0080, 16'h0080, 16'h0000); end
      4'd5:  begin e.cm = 1'b1; e.addr = 9'h014; e.keep = 16'h1000;
                   e.val = pick3(s, 16'h134D, 16'h10C3, 16'h1083); end
      4'd6:  begin e.cm = 1'b1; e.addr = 9'h015; e.keep = 16'h8000; e.zero = 16'h0300;
                   e.val = pick3(s, 16'h0000, 16'h0000, 16'h0080); end
      4'd7:  begin e.cm = 1'b1; e.addr = 9'h016; e.keep = 16'hC000;
                   e.val = pick3(s, 16'h2083, 16'h0041, 16'h1041); end
      4'd8:  begin e.cm = 1'b1; e.addr = 9'h018; e.keep = 16'hFC00;
                   e.val = pick3(s, 16'h0177, 16'h03E8, 16'h03E8); end
      4'd9:  begin e.cm = 1'b1; e.addr = 9'h019; e.keep = 16'h8000;
                   e.val = pick3(s, 16'h7C01, 16'h4401, 16'h3801); end
      4'd10: begin e.cm = 1'b1; e.addr = 9'h01A; e.keep = 16'h8000;
                   e.val = pick3(s, 16'hFFE9, 16'hC7E9, 16'hBBE9); end
      4'd11: begin e.cm = 1'b1; e.addr = 9'h04E; e.keep = 16'h66FF;
                   e.val = pick3(s, 16'h0908, 16'h9808, 16'h9108); end
      4'd12: begin e.cm = 1'b1; e.addr = 9'h04F; e.keep = 16'h666F;
                   e.val = pick3(s, 16'h1000, 16'h8900, 16'h1900); end
      default: ;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/lrr_rate_table.sv
module lrr_rate_table
  import lrr_pkg::*;
(
  input  rate_e            rate_i,
  input  logic [IDX_W-1:0] idx_i,
  output entry_t           entry_o
);
  always_comb entry_o = lookup(rate_i, idx_i);
endmodule

// File: rtl/lrr_drp_access.sv
module lrr_drp_access
  import lrr_pkg::*;
#(
  parameter int AW = DRP_AW,
  parameter int DW = DRP_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  entry_t        entry_i,
  output logic          done_o,
  output logic          drp_en_o,
  output logic          drp_we_o,
  output logic          drp_tgt_o,
  output logic [AW-1:0] drp_addr_o,
  output logic [DW-1:0] drp_di_o,
  input  logic [DW-1:0] drp_do_i,
  input  logic          drp_rdy_i
);
  typedef enum logic [2:0] {E_IDLE, E_RD, E_RDW, E_WR, E_WRW} est_e;
  est_e          st_q;
  entry_t        req_q;
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= E_IDLE;
      req_q <= '0;
      rd_q  <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (go_i) begin
          req_q <= entry_i;
          rd_q  <= '0;
          st_q  <= entry_i.cm ? E_RD : E_WR;
        end
        E_RD:  st_q <= E_RDW;
        E_RDW: if (drp_rdy_i) begin
          rd_q <= drp_do_i;
          st_q <= E_WR;
        end
        E_WR:  st_q <= E_WRW;
        E_WRW: if (drp_rdy_i) st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign drp_en_o   = (st_q == E_RD) || (st_q == E_WR);
  assign drp_we_o   = (st_q == E_WR);
  assign drp_tgt_o  = req_q.cm;
  assign drp_addr_o = req_q.addr;
  assign drp_di_o   = ((rd_q & req_q.keep) | (req_q.val & ~req_q.keep)) & ~req_q.zero;
  assign done_o     = (st_q == E_WRW) && drp_rdy_i;

  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_en_o |=> !drp_en_o);
  a_r4_write_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drp_en_o && drp_we_o && drp_tgt_o) |-> $past(drp_rdy_i));
  a_r6_zero_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drp_en_o && drp_we_o && drp_tgt_o && (drp_addr_o == 9'h009 || drp_addr_o == 9'h015))
    |-> (drp_di_o[9:8] == 2'b00));
endmodule

// File: rtl/lrr_seq_ctrl.sv
module lrr_seq_ctrl
  import lrr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              eng_done_i,
  input  logic              cm_locked_i,
  output logic              go_o,
  output logic [IDX_W-1:0]  idx_o,
  output rate_e             rate_o,
  output logic              cm_rst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);
  localparam logic [IDX_W-1:0] LAST_CH  = IDX_W'(N_CH - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_LOCK} sst_e;
  sst_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      idx_o    <= '0;
      rate_o   <= RATE_2G0;
      cm_rst_o <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          done_o <= 1'b0;
          if (rate_sel_i < RATE_W'(4)) begin
            rate_o <= rate_e'(rate_sel_i[1:0]);
            idx_o  <= '0;
            err_o  <= 1'b0;
            st_q   <= S_ISSUE;
          end else begin
            err_o  <= 1'b1;
          end
        end
        S_ISSUE: st_q <= S_WAIT;
        S_WAIT: if (eng_done_i) begin
          if (idx_o == LAST_IDX) begin
            cm_rst_o <= 1'b0;
            st_q     <= S_LOCK;
          end else begin
            if (idx_o == LAST_CH) cm_rst_o <= 1'b1;
            idx_o <= idx_o + 1'b1;
            st_q  <= S_ISSUE;
          end
        end
        S_LOCK: if (cm_locked_i) begin
          done_o <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign go_o   = (st_q == S_ISSUE);
  assign busy_o = (st_q != S_IDLE);

  a_r10_done_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cm_locked_i) && !cm_rst_o));
  a_r12_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  a_r11_rate_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(rate_o));
endmodule

// File: rtl/lrr_seq_top.sv
module lrr_seq_top
  import lrr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              drp_en_o,
  output logic              drp_we_o,
  output logic              drp_tgt_o,
  output logic [DRP_AW-1:0] drp_addr_o,
  output logic [DRP_DW-1:0] drp_di_o,
  input  logic [DRP_DW-1:0] drp_do_i,
  input  logic              drp_rdy_i,
  output logic              cm_rst_o,
  input  logic              cm_locked_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic             go, eng_done;
  logic [IDX_W-1:0] idx;
  rate_e            rate;
  entry_t           entry;

  lrr_seq_ctrl i_ctrl (
    .clk_i, .rst_ni, .start_i, .rate_sel_i,
    .eng_done_i (eng_done),
    .cm_locked_i,
    .go_o       (go),
    .idx_o      (idx),
    .rate_o     (rate),
    .cm_rst_o, .busy_o, .done_o, .err_o
  );

  lrr_rate_table i_table (
    .rate_i  (rate),
    .idx_i   (idx),
    .entry_o (entry)
  );

  lrr_drp_access i_drp (
    .clk_i, .rst_ni,
    .go_i    (go),
    .entry_i (entry),
    .done_o  (eng_done),
    .drp_en_o, .drp_we_o, .drp_tgt_o, .drp_addr_o, .drp_di_o,
    .drp_do_i, .drp_rdy_i
  );

  a_r9_cm_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drp_en_o && drp_tgt_o) |-> cm_rst_o);
  a_r12_no_access_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !drp_en_o);
endmodule

// File: tb/test_lrr_seq_top.sv
`timescale 1ns/1ps
module test_lrr_seq_top;
  typedef struct packed {logic tgt; logic we; logic [8:0] addr; logic [15:0] data;} exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  rate = '0;
  logic        drp_en, drp_we, drp_tgt, drp_rdy = 1'b0, cm_rst, locked = 1'b0;
  logic [8:0]  drp_addr;
  logic [15:0] drp_di, drp_do = '0;
  logic        busy, done, err;

  int n_run = 0, n_fail = 0, n_acc = 0, rel_cnt = 0;
  exp_t exp_q[$];
  logic [15:0] cm_mem [0:127];
  logic [15:0] ch_mem [0:255];

  always #2.5 clk = ~clk;

  lrr_seq_top i_lrr_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_sel_i(rate),
    .drp_en_o(drp_en), .drp_we_o(drp_we), .drp_tgt_o(drp_tgt), .drp_addr_o(drp_addr),
    .drp_di_o(drp_di), .drp_do_i(drp_do), .drp_rdy_i(drp_rdy),
    .cm_rst_o(cm_rst), .cm_locked_i(locked),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] cm_addr(int k);
    case (k)
      0: return 9'h008; 1: return 9'h009; 2: return 9'h014; 3: return 9'h015;
      4: return 9'h016; 5: return 9'h018; 6: return 9'h019; 7: return 9'h01A;
      8: return 9'h04E; default: return 9'h04F;
    endcase
  endfunction

  function automatic logic [15:0] cm_keep(int k);
    case (k)
      0, 2: return 16'h1000; 3, 6, 7: return 16'h8000; 4: return 16'hC000;
      5: return 16'hFC00; 8: return 16'h66FF; 9: return 16'h666F; default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] cm_val(int r, int k);
    logic [15:0] v0 [10] = '{16'h1187,16'h0080,16'h134D,16'h0000,16'h2083,16'h0177,16'h7C01,16'hFFE9,16'h0908,16'h1000};
    logic [15:0] v1 [10] = '{16'h1042,16'h0080,16'h10C3,16'h0000,16'h0041,16'h03E8,16'h4401,16'hC7E9,16'h9808,16'h8900};
    logic [15:0] v2 [10] = '{16'h1104,16'h0000,16'h1083,16'h0080,16'h1041,16'h03E8,16'h3801,16'hBBE9,16'h9108,16'h1900};
    if (r == 0) return v0[k];
    if (r == 2) return v2[k];
    return v1[k];  // R7: code 3 reuses code 1
  endfunction

  // driver side of the scoreboard
  task automatic push_run(input int r);
    exp_t e;
    logic [15:0] m;
    e = '{1'b0, 1'b1, 9'h05E, (r == 0) ? 16'h1002 : 16'h1082}; exp_q.push_back(e);
    e = '{1'b0, 1'b1, 9'h088, (r == 3) ? 16'h0000 : 16'h0011}; exp_q.push_back(e);
    e = '{1'b0, 1'b1, 9'h0A9, (r == 3) ? 16'h1040 : 16'h1020}; exp_q.push_back(e);
    for (int k = 0; k < 10; k++) begin
      e = '{1'b1, 1'b0, cm_addr(k), 16'h0000}; exp_q.push_back(e);
      m = (cm_mem[cm_addr(k)] & cm_keep(k)) | (cm_val(r, k) & ~cm_keep(k));
      if (k == 1 || k == 3) m[9:8] = 2'b00;
      e = '{1'b1, 1'b1, cm_addr(k), m}; exp_q.push_back(e);
    end
  endtask

  // monitor, DRP slave and lock model
  int pend = 0;
  logic [15:0] rd_hold = '0;
  logic done_prev = 1'b0, rst_prev = 1'b0;
  initial forever begin
    @(negedge clk);
    if (drp_rdy) drp_rdy = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin drp_rdy = 1'b1; drp_do = rd_hold; end
    end
    if (drp_en) begin
      exp_t e;
      n_acc++;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected access", drp_addr, 0);
      else begin
        e = exp_q.pop_front();
        chk(drp_tgt == e.tgt && drp_we == e.we && drp_addr == e.addr, "R2 order tgt/we/addr",
            {drp_tgt, drp_we, drp_addr}, {e.tgt, e.we, e.addr});
        if (e.we) chk(drp_di == e.data, "R3/R5/R6/R7 write data", drp_di, e.data);
      end
      if (drp_tgt) chk(cm_rst, "R9 clock manager in reset", cm_rst, 1);
      if (drp_tgt) begin
        if (drp_we) cm_mem[drp_addr[6:0]] = drp_di; else rd_hold = cm_mem[drp_addr[6:0]];
      end else begin
        if (drp_we) ch_mem[drp_addr[7:0]] = drp_di; else rd_hold = ch_mem[drp_addr[7:0]];
      end
      pend = 1 + (n_acc % 3);
    end
    if (cm_rst) begin locked = 1'b0; rel_cnt = 0; end
    else begin
      if (rst_prev) rel_cnt = 0;
      rel_cnt++;
      if (rel_cnt >= 6) locked = 1'b1;
    end
    if (done && !done_prev)
      chk(locked && !cm_rst && rel_cnt >= 6, "R10 done after lock", rel_cnt, 6);
    done_prev = done;
    rst_prev  = cm_rst;
  end

  task automatic pulse_start(input int r);
    @(negedge clk); rate = 3'(r); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input int r, input logic [15:0] fill, input bit poke);
    int base, t;
    for (int a = 0; a < 128; a++) cm_mem[a] = fill;
    base = n_acc;
    push_run(r);
    pulse_start(r);
    chk(busy, "R10 busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      rate = 3'd3; start = 1'b1;  // R11: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, "R10 done reached", done, 1);
    chk(!busy && !cm_rst, "R9 reset released, idle", {busy, cm_rst}, 0);
    chk(exp_q.size() == 0, "R2 all entries issued", exp_q.size(), 0);
    chk(n_acc - base == 23, "R2/R4 access count", n_acc - base, 23);
    repeat (5) @(negedge clk);
    chk(done, "R10 done holds", done, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    for (int a = 0; a < 256; a++) ch_mem[a] = 16'h0000;
    for (int a = 0; a < 128; a++) cm_mem[a] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1 reset status", {busy, done, err}, 0);
    chk(!drp_en && !cm_rst, "R1 reset drp/cm", {drp_en, cm_rst}, 0);

    run(1, 16'hFFFF, 1'b0);
    run(0, 16'h0000, 1'b0);
    run(2, 16'hA5A5, 1'b0);
    run(3, 16'h5A5A, 1'b0);

    base = n_acc;
    pulse_start(6);
    @(negedge clk);
    chk(err && !busy, "R12 error set", {err, busy}, 2);
    chk(!done, "R12 done cleared", done, 0);
    repeat (30) @(negedge clk);
    chk(n_acc == base, "R12 no access", n_acc - base, 0);

    run(0, 16'hFFFF, 1'b1);
    chk(!err, "R12 error cleared by valid start", err, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule